// File: doc/BRIEF.md
# Alarm Indication Signal Detector

The block monitors a recovered serial line, one data bit per clock when the bit-enable input is high. It looks for an alarm indication signal, which is a stream that is almost entirely ones. It counts enabled bits into consecutive fixed-length windows that do not overlap, and counts the zeros inside each window. At the end of each window it makes one decision. A window with few zeros raises the live alarm. A window with many zeros drops it. A window whose zero count sits exactly on the threshold keeps the previous state, which gives hysteresis.

A sticky copy of the alarm holds the event for a host. It is set whenever the alarm is declared. A read strobe clears it, but only when the live alarm is already low. An optional output pin follows the live alarm while coder mode is selected and stays low otherwise. A power-down input forces every indication low and restarts window counting. With the default parameters the window is 8192 bits, the alarm is declared below 9 zeros and cleared above 9 zeros.

Top module: `ais_detector`

## Requirements
- R1: A window is WIN_BITS consecutive cycles in which bit_en_i is high. Cycles with bit_en_i low are ignored entirely, and windows follow one another back to back without overlap.
- R2: When a completed window holds fewer than ZERO_THRESH zeros (bit_i = 0), ais_o goes high.
- R3: When a completed window holds more than ZERO_THRESH zeros, ais_o goes low.
- R4: When a completed window holds exactly ZERO_THRESH zeros, ais_o keeps its previous value.
- R5: The zero count saturates and does not wrap. A window made entirely of zeros always clears the alarm.
- R6: ais_o changes only at a window end. The new value is visible in the cycle after the clock edge that accepts the last bit of the window.
- R7: ais_latched_o goes high together with any declaration. It drops only after a clock edge at which rd_strobe_i is high and ais_o was already low. A read while the alarm is active leaves it set.
- R8: ais_pin_o equals ais_o while coder_mode_i is high, and is 0 while coder_mode_i is low.
- R9: While pwr_down_i is high, ais_o, ais_latched_o and ais_pin_o are 0. Power-down clears both alarm bits and discards the partial window, so a new full window starts after release.
- R10: After reset all outputs are 0, and no decision is made until a full window has been received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | Qualifies bit_i in this cycle |
| bit_i | input | 1 | Recovered line data bit |
| pwr_down_i | input | 1 | Channel power-down |
| coder_mode_i | input | 1 | Enables the external alarm pin |
| rd_strobe_i | input | 1 | Host read of the latched status |
| ais_o | output | 1 | Live alarm status |
| ais_latched_o | output | 1 | Sticky alarm status |
| ais_pin_o | output | 1 | External alarm pin, active in coder mode |

## Verification
Two situations are hard to reach from the ports: a zero count that would overflow a narrow counter, and a window boundary that becomes misaligned after power-down. The bench uses a small configuration (16-bit window, threshold 3). In that configuration it sweeps every possible zero count of a window, starting once from the declared state and once from the cleared state, and spreads the zeros across the window with idle cycles placed between the bits. For the power-down case, it leaves a window half filled with zeros, powers the channel down, and then checks that the next full all-ones window alone decides the state.

// File: rtl/ais_pkg.sv
package ais_pkg;
  typedef enum logic [1:0] {
    VERDICT_HOLD  = 2'd0,
    VERDICT_SET   = 2'd1,
    VERDICT_CLEAR = 2'd2
  } verdict_e;
endpackage

// File: rtl/ais_win_ctr.sv
module ais_win_ctr #(
  parameter int unsigned WIN_BITS = 8192
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flush_i,
  input  logic bit_en_i,
  output logic last_o
);
  localparam int unsigned CW = (WIN_BITS > 2) ? $clog2(WIN_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(WIN_BITS - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = bit_en_i && !flush_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (flush_i || last_o) begin
      cnt_q <= '0;
    end else if (bit_en_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ais_zero_ctr.sv
module ais_zero_ctr
  import ais_pkg::*;
#(
  parameter int unsigned ZERO_THRESH = 9
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     flush_i,
  input  logic     bit_en_i,
  input  logic     bit_i,
  input  logic     win_last_i,
  output verdict_e verdict_o
);
  // only needs to reach one past the threshold
  localparam int unsigned SAT = ZERO_THRESH + 1;
  localparam int unsigned ZW  = $clog2(SAT + 1);
  localparam logic [ZW-1:0] SAT_V = ZW'(SAT);
  localparam logic [ZW-1:0] THR_V = ZW'(ZERO_THRESH);

  logic [ZW-1:0] cnt_q, cnt_next;

  always_comb begin
    cnt_next = cnt_q;
    if (bit_en_i && !bit_i && (cnt_q != SAT_V)) cnt_next = cnt_q + 1'b1;
  end

  always_comb begin
    verdict_o = VERDICT_HOLD;
    if (win_last_i) begin
      if (cnt_next < THR_V)      verdict_o = VERDICT_SET;
      else if (cnt_next > THR_V) verdict_o = VERDICT_CLEAR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (flush_i || win_last_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_next;
    end
  end
endmodule

// File: rtl/ais_status.sv
module ais_status
  import ais_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     flush_i,
  input  verdict_e verdict_i,
  input  logic     rd_strobe_i,
  output logic     live_o,
  output logic     latch_o
);
  logic live_q, latch_q;
  logic set_w, clr_w, rd_clr_w;

  assign set_w    = (verdict_i == VERDICT_SET);
  assign clr_w    = (verdict_i == VERDICT_CLEAR);
  assign rd_clr_w = rd_strobe_i && !live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= 1'b0;
      latch_q <= 1'b0;
    end else if (flush_i) begin
      live_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      if (set_w)      live_q <= 1'b1;
      else if (clr_w) live_q <= 1'b0;
      if (set_w)         latch_q <= 1'b1;
      else if (rd_clr_w) latch_q <= 1'b0;
    end
  end

  assign live_o  = live_q;
  assign latch_o = latch_q;
endmodule

// File: rtl/ais_detector.sv
module ais_detector
  import ais_pkg::*;
#(
  parameter int unsigned WIN_BITS    = 8192,
  parameter int unsigned ZERO_THRESH = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_en_i,
  input  logic bit_i,
  input  logic pwr_down_i,
  input  logic coder_mode_i,
  input  logic rd_strobe_i,
  output logic ais_o,
  output logic ais_latched_o,
  output logic ais_pin_o
);
  logic     win_last;
  verdict_e verdict;
  logic     live, latch;

  ais_win_ctr #(.WIN_BITS(WIN_BITS)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (pwr_down_i),
    .bit_en_i (bit_en_i),
    .last_o   (win_last)
  );

  ais_zero_ctr #(.ZERO_THRESH(ZERO_THRESH)) u_zero (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_i    (pwr_down_i),
    .bit_en_i   (bit_en_i),
    .bit_i      (bit_i),
    .win_last_i (win_last),
    .verdict_o  (verdict)
  );

  ais_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (pwr_down_i),
    .verdict_i   (verdict),
    .rd_strobe_i (rd_strobe_i),
    .live_o      (live),
    .latch_o     (latch)
  );

  assign ais_o         = live && !pwr_down_i;
  assign ais_latched_o = latch && !pwr_down_i;
  assign ais_pin_o     = ais_o && coder_mode_i;
endmodule

// File: rtl/ais_detector_chk.sv
module ais_detector_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_down_i,
  input logic coder_mode_i,
  input logic rd_strobe_i,
  input logic ais_o,
  input logic ais_latched_o,
  input logic ais_pin_o,
  input logic win_last
);
  assert_pin_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ais_pin_o == (ais_o && coder_mode_i));

  assert_pwr_down_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_down_i |-> (!ais_o && !ais_latched_o && !ais_pin_o));

  assert_latch_covers_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ais_o |-> ais_latched_o);

  assert_latch_clear_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ais_latched_o) && !pwr_down_i) |-> ($past(rd_strobe_i) && !$past(ais_o)));

  assert_window_only_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(win_last) && !$past(pwr_down_i) && !pwr_down_i) |-> $stable(ais_o));
endmodule

bind ais_detector ais_detector_chk u_chk (.*);

// File: tb/ais_detector_test.sv
`timescale 1ns/1ps
module ais_detector_test;
  localparam int WIN = 16;
  localparam int THR = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_en = 1'b0, bit_d = 1'b0, pwr_dn = 1'b0, coder = 1'b1, rd = 1'b0;
  logic ais, ais_l, pin;

  int errors = 0;
  int checks = 0;
  logic exp_ais = 1'b0, exp_lat = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  ais_detector #(.WIN_BITS(WIN), .ZERO_THRESH(THR)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_en_i(bit_en), .bit_i(bit_d),
    .pwr_down_i(pwr_dn), .coder_mode_i(coder), .rd_strobe_i(rd),
    .ais_o(ais), .ais_latched_o(ais_l), .ais_pin_o(pin)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(input string req);
    chk(req, ais, exp_ais);
    chk(req, ais_l, exp_lat);
    chk({req, "/R8"}, pin, exp_ais & coder & !pwr_dn);
  endtask

  // model R2/R3/R4
  task automatic model_window(input int z);
    if (z < THR) begin exp_ais = 1'b1; exp_lat = 1'b1; end
    else if (z > THR) exp_ais = 1'b0;
  endtask

  task automatic send_bits(input int n, input int z);
    for (int i = 0; i < n; i++) begin
      if (i % 4 == 3) begin   // R1 idle cycle with a zero on the line
        @(negedge clk); bit_en = 1'b0; bit_d = 1'b0;
      end
      @(negedge clk); bit_en = 1'b1; bit_d = !(((i * 7) % WIN) < z);
    end
    @(negedge clk); bit_en = 1'b0; bit_d = 1'b0;
  endtask

  task automatic window(input int z, input string req);
    send_bits(WIN, z);
    model_window(z);
    chk_all(req);
  endtask

  task automatic host_read(input string req);
    @(negedge clk); rd = 1'b1;
    if (!exp_ais) exp_lat = 1'b0;
    @(negedge clk); rd = 1'b0;
    chk_all(req);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all("R10 reset");
    rst_ni = 1'b1;
    @(negedge clk);
    // R10: no decision before a full window
    send_bits(WIN - 1, 0);
    chk("R10 early", ais, 1'b0);
    @(negedge clk); bit_en = 1'b1; bit_d = 1'b1;
    @(negedge clk); bit_en = 1'b0;
    exp_ais = 1'b1; exp_lat = 1'b1;
    chk_all("R10 first window");

    // R7 read while active keeps latch
    host_read("R7 read active");

    // R6: mid-window no change
    send_bits(WIN / 2, WIN);
    chk("R6 mid window", ais, 1'b1);
    send_bits(WIN / 2, WIN);
    exp_ais = 1'b0;
    chk_all("R6/R5 window end");
    host_read("R7 read idle");

    // sweep every zero count from both states, both coder settings
    for (int m = 0; m < 2; m++) begin
      coder = (m == 0);
      for (int z = 0; z <= WIN; z++) begin
        window(0, "R2 prime set");
        window(z, (z < THR) ? "R2 from set" : (z == THR) ? "R4 from set" :
                  (z == WIN) ? "R5 from set" : "R3 from set");
        window(WIN, "R5 prime clear");
        window(z, (z < THR) ? "R2 from clear" : (z == THR) ? "R4 from clear" :
                  "R3 from clear");
        host_read("R7 sweep read");
      end
    end
    coder = 1'b1;

    // R9: power-down forces low and restarts the window
    window(0, "R9 prime");
    send_bits(WIN / 2, WIN);
    @(negedge clk); pwr_dn = 1'b1;
    #1 chk("R9 forced ais", ais, 1'b0);
    chk("R9 forced latch", ais_l, 1'b0);
    chk("R9 forced pin", pin, 1'b0);
    exp_ais = 1'b0; exp_lat = 1'b0;
    @(negedge clk); @(negedge clk); pwr_dn = 1'b0;
    @(negedge clk);
    chk_all("R9 after release");
    window(0, "R9 realigned window");
    send_bits(WIN / 2, 0);
    chk("R9 no early decision", ais, 1'b1);
    send_bits(WIN / 2, WIN);
    exp_ais = 1'b0;
    chk_all("R1 window boundary");

    finished = 1'b1;
    report();
  end
endmodule